// File: doc/BRIEF.md
# Right-Port Bus Width Matcher

This block sits between a memory array of 36-bit words and a right-side data port whose width can be set to 36, 18 or 9 bits. The word is handled as four 9-bit lanes. Two static configuration inputs choose the port mode. Two lane-address inputs act as extra low-order address bits that pick which half-word or which lane a narrow access moves. The memory array is not part of the block.

On a read, the block steers the chosen lanes of the memory word onto the low pins of the port. It drives a separate output enable for each 9-bit pin group, so pins that a narrow mode leaves unused stay in high impedance. On a write, it copies the narrow port data onto every lane position the access could reach. It then raises the write enable of only the addressed lanes, so the other lanes keep their contents. A fourth mode turns off every port data pin while the port is selected, and it marks the access as a flag access instead of a memory access.

The configuration is captured in a register on every clock. An access is honoured only once the inputs match the registered value, and only from the second clock after reset.

Top module: `bus_width_matcher`

## Requirements
- R1: The mode is {cfg_narrow,cfg_alt}: 00 is 36-bit, 01 is I/O-disabled, 10 is 18-bit and 11 is 9-bit. The mode in use is the one registered at the last clock. In any cycle where the inputs differ from that registered value, mem_lane_we is 0, pin_oe is 0 and flag_sel is 0.
- R2: While rst_n is low, and during the first cycle after it is released, mem_lane_we, pin_oe, pin_dout and flag_sel are all 0.
- R3: In 36-bit mode, a write raises all four bits of mem_lane_we and puts pin_din on mem_wdata. sel_hi and sel_lo have no effect.
- R4: In 36-bit mode, a read sets pin_oe to 4'b1111 and puts mem_rdata on pin_dout. sel_hi and sel_lo have no effect.
- R5: In 18-bit mode, a read sets pin_oe to 4'b0011. pin_dout[17:0] carries mem_rdata[17:0] when sel_hi is 0 and mem_rdata[35:18] when sel_hi is 1. pin_dout[35:18] is 0, and sel_lo has no effect.
- R6: In 18-bit mode, a write raises mem_lane_we 4'b0011 when sel_hi is 0 and 4'b1100 when sel_hi is 1. pin_din[17:0] appears on both halves of mem_wdata.
- R7: In 9-bit mode, a read sets pin_oe to 4'b0001. pin_dout[8:0] carries memory lane k = 2*sel_hi+sel_lo, which is mem_rdata[9k+8:9k]. pin_dout[35:9] is 0.
- R8: In 9-bit mode, a write raises only mem_lane_we[k], with k = 2*sel_hi+sel_lo. pin_din[8:0] appears on every lane of mem_wdata.
- R9: In I/O-disabled mode, pin_oe and mem_lane_we stay 0. flag_sel is 1 exactly when acc_en is 1 and accesses are honoured.
- R10: A read is acc_en=1, acc_we=0 and acc_oe=1. In every other case pin_oe is 0 and pin_dout is 0.
- R11: With acc_en at 0, mem_lane_we is 0 and flag_sel is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_narrow | input | 1 | Mode bit 1 (static) |
| cfg_alt | input | 1 | Mode bit 0 (static) |
| sel_hi | input | 1 | Upper lane-address bit (half select) |
| sel_lo | input | 1 | Lower lane-address bit (lane within half) |
| acc_en | input | 1 | Port selected |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_oe | input | 1 | Port output enable |
| pin_din | input | 36 | Data arriving from the port pins |
| pin_dout | output | 36 | Data to the port pins |
| pin_oe | output | 4 | Output enable per 9-bit pin group |
| mem_rdata | input | 36 | Word read from the memory array |
| mem_wdata | output | 36 | Word written to the memory array |
| mem_lane_we | output | 4 | Write enable per 9-bit memory lane |
| flag_sel | output | 1 | Access is directed to the flag logic |

## Verification
A configuration change and a port access can arrive in the same cycle. The access must then be suppressed, whether it is a read, a write or a flag access. The bench provokes this by changing the mode in the very step that presents a selected access. It also releases reset in the same cycle as a pending write. A behavioural model tracks the registered mode and the arming after reset. Every cycle it predicts lane enables, pin enables, steered data and the flag, and these predictions are compared with the block's outputs.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

    localparam int NUM_LANES = 4;
    localparam int HALF      = NUM_LANES / 2;
    localparam int SEL_W     = $clog2(NUM_LANES);

    typedef enum logic [1:0] {
        MODE_W36 = 2'b00,
        MODE_OFF = 2'b01,
        MODE_W18 = 2'b10,
        MODE_W9  = 2'b11
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  armed;
    } cfg_state_t;

endpackage

// File: rtl/bwm_cfg_reg.sv
module bwm_cfg_reg
    import bwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_in,
    output mode_e      mode_q,
    output logic       access_ok
);

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.mode  = mode_e'(cfg_in);
        st_d.armed = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_W36, armed: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_q    = st_q.mode;
    assign access_ok = st_q.armed && (cfg_in == st_q.mode);

endmodule

// File: rtl/bwm_lane_decode.sv
module bwm_lane_decode
    import bwm_pkg::*;
(
    input  mode_e                mode,
    input  logic                 sel_hi,
    input  logic                 sel_lo,
    output logic [NUM_LANES-1:0] lane_mask,
    output logic [NUM_LANES-1:0] grp_mask
);

    logic [SEL_W-1:0] lane_idx;
    assign lane_idx = {sel_hi, sel_lo};

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        always_comb begin
            unique case (mode)
                MODE_W36: begin
                    lane_mask[i] = 1'b1;
                    grp_mask[i]  = 1'b1;
                end
                MODE_W18: begin
                    lane_mask[i] = ((i / HALF) == int'(sel_hi));
                    grp_mask[i]  = (i < HALF);
                end
                MODE_W9: begin
                    lane_mask[i] = (i == int'(lane_idx));
                    grp_mask[i]  = (i == 0);
                end
                default: begin
                    lane_mask[i] = 1'b0;
                    grp_mask[i]  = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/bwm_read_steer.sv
module bwm_read_steer
    import bwm_pkg::*;
#(
    parameter int LANE_W = 9,
    localparam int WORD_W = LANE_W * NUM_LANES
) (
    input  mode_e                mode,
    input  logic                 sel_hi,
    input  logic                 sel_lo,
    input  logic                 rd_go,
    input  logic [NUM_LANES-1:0] grp_mask,
    input  logic [WORD_W-1:0]    mem_rdata,
    output logic [WORD_W-1:0]    pin_dout,
    output logic [NUM_LANES-1:0] pin_oe
);

    logic [LANE_W-1:0] lane_rd  [NUM_LANES];
    logic [LANE_W-1:0] lane_raw [NUM_LANES];
    logic [SEL_W-1:0]  lane_idx;

    assign lane_idx = {sel_hi, sel_lo};

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_grp
        assign lane_rd[g] = mem_rdata[g*LANE_W +: LANE_W];

        if (g == 0) begin : g_first
            always_comb begin
                unique case (mode)
                    MODE_W36: lane_raw[g] = lane_rd[g];
                    MODE_W18: lane_raw[g] = sel_hi ? lane_rd[HALF+g] : lane_rd[g];
                    MODE_W9:  lane_raw[g] = lane_rd[lane_idx];
                    default:  lane_raw[g] = '0;
                endcase
            end
        end else if (g < HALF) begin : g_low
            always_comb begin
                unique case (mode)
                    MODE_W36: lane_raw[g] = lane_rd[g];
                    MODE_W18: lane_raw[g] = sel_hi ? lane_rd[HALF+g] : lane_rd[g];
                    default:  lane_raw[g] = '0;
                endcase
            end
        end else begin : g_high
            always_comb begin
                lane_raw[g] = (mode == MODE_W36) ? lane_rd[g] : '0;
            end
        end

        assign pin_oe[g]                    = rd_go & grp_mask[g];
        assign pin_dout[g*LANE_W +: LANE_W] = pin_oe[g] ? lane_raw[g] : '0;
    end

endmodule

// File: rtl/bwm_write_steer.sv
module bwm_write_steer
    import bwm_pkg::*;
#(
    parameter int LANE_W = 9,
    localparam int WORD_W = LANE_W * NUM_LANES
) (
    input  mode_e                mode,
    input  logic                 wr_go,
    input  logic [NUM_LANES-1:0] lane_mask,
    input  logic [WORD_W-1:0]    pin_din,
    output logic [WORD_W-1:0]    mem_wdata,
    output logic [NUM_LANES-1:0] mem_lane_we
);

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        localparam int SRC18 = i % HALF;

        always_comb begin
            unique case (mode)
                MODE_W18: mem_wdata[i*LANE_W +: LANE_W] = pin_din[SRC18*LANE_W +: LANE_W];
                MODE_W9:  mem_wdata[i*LANE_W +: LANE_W] = pin_din[0 +: LANE_W];
                default:  mem_wdata[i*LANE_W +: LANE_W] = pin_din[i*LANE_W +: LANE_W];
            endcase
        end

        assign mem_lane_we[i] = wr_go & lane_mask[i];
    end

endmodule

// File: rtl/bus_width_matcher.sv
module bus_width_matcher
    import bwm_pkg::*;
#(
    parameter int LANE_W = 9,
    localparam int WORD_W = LANE_W * NUM_LANES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_narrow,
    input  logic                 cfg_alt,
    input  logic                 sel_hi,
    input  logic                 sel_lo,
    input  logic                 acc_en,
    input  logic                 acc_we,
    input  logic                 acc_oe,
    input  logic [WORD_W-1:0]    pin_din,
    output logic [WORD_W-1:0]    pin_dout,
    output logic [NUM_LANES-1:0] pin_oe,
    input  logic [WORD_W-1:0]    mem_rdata,
    output logic [WORD_W-1:0]    mem_wdata,
    output logic [NUM_LANES-1:0] mem_lane_we,
    output logic                 flag_sel
);

    mode_e                mode;
    logic                 access_ok;
    logic                 go;
    logic                 rd_go;
    logic                 wr_go;
    logic [NUM_LANES-1:0] lane_mask;
    logic [NUM_LANES-1:0] grp_mask;

    bwm_cfg_reg i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_in    ({cfg_narrow, cfg_alt}),
        .mode_q    (mode),
        .access_ok (access_ok)
    );

    assign go       = acc_en & access_ok;
    assign rd_go    = go & ~acc_we & acc_oe;
    assign wr_go    = go & acc_we;
    assign flag_sel = go & (mode == MODE_OFF);

    bwm_lane_decode i_dec (
        .mode      (mode),
        .sel_hi    (sel_hi),
        .sel_lo    (sel_lo),
        .lane_mask (lane_mask),
        .grp_mask  (grp_mask)
    );

    bwm_read_steer #(.LANE_W(LANE_W)) i_rd (
        .mode      (mode),
        .sel_hi    (sel_hi),
        .sel_lo    (sel_lo),
        .rd_go     (rd_go),
        .grp_mask  (grp_mask),
        .mem_rdata (mem_rdata),
        .pin_dout  (pin_dout),
        .pin_oe    (pin_oe)
    );

    bwm_write_steer #(.LANE_W(LANE_W)) i_wr (
        .mode        (mode),
        .wr_go       (wr_go),
        .lane_mask   (lane_mask),
        .pin_din     (pin_din),
        .mem_wdata   (mem_wdata),
        .mem_lane_we (mem_lane_we)
    );

endmodule

// File: rtl/bwm_checker.sv
module bwm_checker
    import bwm_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_narrow,
    input logic                 cfg_alt,
    input logic                 acc_en,
    input logic                 acc_we,
    input logic                 acc_oe,
    input logic [NUM_LANES-1:0] pin_oe,
    input logic [NUM_LANES-1:0] mem_lane_we,
    input logic                 flag_sel
);

    logic [1:0] cfg;
    assign cfg = {cfg_narrow, cfg_alt};

    // R1
    cfg_change_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg != $past(cfg)) |-> (mem_lane_we == '0 && pin_oe == '0 && !flag_sel));

    // R2
    first_cycle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (mem_lane_we == '0 && pin_oe == '0 && !flag_sel));

    // R6
    half_write_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg == 2'b10 && $past(cfg) == 2'b10) |->
        (mem_lane_we == 4'b0000 || mem_lane_we == 4'b0011 || mem_lane_we == 4'b1100));

    // R8
    lane_write_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg == 2'b11 && $past(cfg) == 2'b11) |-> ($countones(mem_lane_we) <= 1));

    // R9
    off_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg == 2'b01 && $past(cfg) == 2'b01) |-> (pin_oe == '0 && mem_lane_we == '0));

    // R9
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_sel |-> (pin_oe == '0 && mem_lane_we == '0));

    // R10
    drive_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe != '0) |-> (acc_en && !acc_we && acc_oe));

    // R11
    idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |-> (mem_lane_we == '0 && !flag_sel));

endmodule

bind bus_width_matcher bwm_checker i_bwm_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_narrow  (cfg_narrow),
    .cfg_alt     (cfg_alt),
    .acc_en      (acc_en),
    .acc_we      (acc_we),
    .acc_oe      (acc_oe),
    .pin_oe      (pin_oe),
    .mem_lane_we (mem_lane_we),
    .flag_sel    (flag_sel)
);

// File: tb/test_bus_width_matcher.sv
`timescale 1ns/1ps
module test_bus_width_matcher;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_narrow = 1'b0, cfg_alt = 1'b0;
    logic        sel_hi = 1'b0, sel_lo = 1'b0;
    logic        acc_en = 1'b0, acc_we = 1'b0, acc_oe = 1'b0;
    logic [35:0] pin_din = '0, mem_rdata = '0;
    logic [35:0] pin_dout, mem_wdata;
    logic [3:0]  pin_oe, mem_lane_we;
    logic        flag_sel;

    int tests = 0;
    int fails = 0;
    int m_cfg = 0;
    int m_armed = 0;

    always #10 clk = ~clk;

    bus_width_matcher i_bus_width_matcher (
        .clk(clk), .rst_n(rst_n), .cfg_narrow(cfg_narrow), .cfg_alt(cfg_alt),
        .sel_hi(sel_hi), .sel_lo(sel_lo), .acc_en(acc_en), .acc_we(acc_we),
        .acc_oe(acc_oe), .pin_din(pin_din), .pin_dout(pin_dout), .pin_oe(pin_oe),
        .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .mem_lane_we(mem_lane_we),
        .flag_sel(flag_sel)
    );

    task automatic compare(input string tag);
        logic [3:0]  e_we = '0, e_oe = '0;
        logic [35:0] e_dout = '0, e_wd = '0, wmask = '0;
        logic        e_flag = 1'b0;
        int cur = {cfg_narrow, cfg_alt};
        int idx = 2 * sel_hi + sel_lo;
        bit ok = (rst_n == 1'b1) && (m_armed != 0) && (cur == m_cfg);
        if (ok && acc_en) begin
            if (m_cfg == 1) e_flag = 1'b1;
            else if (acc_we) begin
                if (m_cfg == 0) begin e_we = 4'hF; e_wd = pin_din; end
                else if (m_cfg == 2) begin
                    e_we = sel_hi ? 4'hC : 4'h3;
                    e_wd = {pin_din[17:0], pin_din[17:0]};
                end else begin
                    e_we = 4'(1 << idx);
                    e_wd = {4{pin_din[8:0]}};
                end
            end else if (acc_oe) begin
                if (m_cfg == 0) begin e_oe = 4'hF; e_dout = mem_rdata; end
                else if (m_cfg == 2) begin
                    e_oe = 4'h3;
                    e_dout = sel_hi ? {18'b0, mem_rdata[35:18]} : {18'b0, mem_rdata[17:0]};
                end else begin
                    e_oe = 4'h1;
                    e_dout = (mem_rdata >> (9 * idx)) & 36'h1FF;
                end
            end
        end
        for (int i = 0; i < 4; i++) if (e_we[i]) wmask[i*9 +: 9] = '1;
        tests++;
        if (mem_lane_we !== e_we || pin_oe !== e_oe || pin_dout !== e_dout ||
            flag_sel !== e_flag || (mem_wdata & wmask) !== (e_wd & wmask)) begin
            fails++;
            $display("FAIL %s: we=%h oe=%h dout=%h flag=%b wd=%h exp we=%h oe=%h dout=%h flag=%b wd=%h",
                     tag, mem_lane_we, pin_oe, pin_dout, flag_sel, mem_wdata & wmask,
                     e_we, e_oe, e_dout, e_flag, e_wd & wmask);
        end
    endtask

    task automatic step(input logic rst_v, input logic [1:0] cfg, input logic hi, lo,
                        input logic en, we, oe, input logic [35:0] din, rdat,
                        input string tag);
        @(posedge clk);
        if (rst_n) begin
            m_cfg   = {cfg_narrow, cfg_alt};
            m_armed = 1;
        end else begin
            m_cfg   = 0;
            m_armed = 0;
        end
        #4;
        rst_n = rst_v;
        {cfg_narrow, cfg_alt} = cfg;
        sel_hi = hi; sel_lo = lo;
        acc_en = en; acc_we = we; acc_oe = oe;
        pin_din = din; mem_rdata = rdat;
        #8;
        compare(tag);
    endtask

    initial begin
        #3_000_000;
        fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [35:0] pat = 36'h9_ABCD_1234;
        logic [35:0] din = 36'h5_1357_9BDF;
        step(0, 2'b00, 0, 0, 1, 1, 0, din, pat, "R2 reset");
        step(0, 2'b00, 0, 0, 1, 0, 1, din, pat, "R2 reset");
        step(1, 2'b00, 0, 0, 1, 1, 0, din, pat, "R2 first cycle");
        step(1, 2'b00, 1, 1, 1, 1, 0, din, pat, "R3");
        step(1, 2'b00, 1, 0, 1, 0, 1, din, pat, "R4");
        step(1, 2'b10, 0, 0, 1, 0, 1, din, pat, "R1 change to 18");
        step(1, 2'b10, 0, 1, 1, 0, 1, din, pat, "R5 low");
        step(1, 2'b10, 1, 0, 1, 0, 1, din, pat, "R5 high");
        step(1, 2'b10, 1, 1, 1, 1, 0, din, pat, "R6 high");
        step(1, 2'b10, 0, 1, 1, 1, 0, 36'h0_0003_FFFF ^ din, pat, "R6 low");
        step(1, 2'b11, 1, 1, 1, 1, 0, din, pat, "R1 change to 9");
        for (int k = 0; k < 4; k++)
            step(1, 2'b11, k[1], k[0], 1, 0, 1, din, pat ^ (36'h1F << (9*k)), "R7");
        for (int k = 0; k < 4; k++)
            step(1, 2'b11, k[1], k[0], 1, 1, 0, din + 36'(k), pat, "R8");
        step(1, 2'b11, 0, 1, 1, 0, 0, din, pat, "R10 oe low");
        step(1, 2'b11, 1, 0, 1, 1, 1, din, pat, "R10 write with oe");
        step(1, 2'b11, 1, 0, 0, 1, 0, din, pat, "R11 idle write");
        step(1, 2'b11, 1, 0, 0, 0, 1, din, pat, "R11 idle read");
        step(1, 2'b01, 0, 0, 1, 0, 1, din, pat, "R1 change to off");
        step(1, 2'b01, 1, 1, 1, 0, 1, din, pat, "R9 read");
        step(1, 2'b01, 0, 0, 1, 1, 0, din, pat, "R9 write");
        step(1, 2'b01, 0, 0, 0, 0, 1, din, pat, "R11 off idle");
        step(1, 2'b00, 0, 1, 1, 0, 1, din, pat, "R1 change to 36");
        step(1, 2'b00, 0, 1, 1, 0, 1, din, ~pat, "R4 again");
        step(1, 2'b00, 1, 0, 1, 1, 0, ~din, pat, "R3 again");
        step(1, 2'b00, 0, 0, 1, 1, 0, din, pat, "R3 repeat");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule